// File: doc/BRIEF.md
# Low-Power SDRAM Refresh and Power-Mode Sequencer

This block sits on the controller side of a low-power SDRAM. It drives the command pins (chip select, row strobe, column strobe, write enable), the clock-enable pin, the address and the bank-select lines. With them it performs four operations: auto refresh, self refresh, power down and deep power down. A host gives it a periodic refresh tick and three level requests for low-power states: sleep, light idle and deep sleep. The host also gives an access request, which blocks new low-power entry and wakes the memory from any low-power state. A `banks_open` level tells the sequencer that rows may be open. In that case it closes them with a precharge-all before it starts any refresh or low-power entry.

The sequencer counts the row-cycle wait after every auto refresh and after self-refresh exit. It counts the precharge wait after a precharge-all and a short wait after the extended mode-register write that comes before self-refresh entry. That write carries a temperature range and a partial-array selection. The sequencer also counts the time spent in power down and leaves that state before the refresh deadline, then refreshes at once. `ready` tells the host when the memory may take an access. `data_lost` records that deep power down has destroyed the array contents.

Top module: `lp_sdram_pwr_seq`

## Requirements
- R1: After reset the pins carry NOP (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1), `cke`=1, `ready`=1 and `data_lost`=0.
- R2: Each refresh tick yields one auto refresh command: `cs_n`, `ras_n`, `cas_n` low, `we_n` high, `cke` high. No precharge follows it. Ticks that arrive close together are queued and served one by one.
- R3: No command appears on the pins within T_RC cycles after an auto refresh. Queued refreshes therefore come exactly T_RC cycles apart.
- R4: If `banks_open` is high when a refresh or low-power entry is chosen, a precharge-all goes first: `cs_n`, `ras_n`, `we_n` low, `cas_n` high, `addr[10]` high. The next command follows exactly T_RP cycles later.
- R5: Self-refresh entry has two steps. First comes an extended mode-register write: all four command pins low, `ba`=2'b10, `addr[4:3]`=`temp_range`, `addr[2:0]`=`pasr_sel`, all other address bits zero. Exactly T_MRD cycles later comes the auto refresh encoding with `cke` low. While `cke` stays low, the pins carry only NOP.
- R6: Self refresh ends when `access_req` is high or `sleep_req` goes low, and `cke` is then raised. No command follows for T_RC cycles. Ticks that arrive during self refresh are discarded.
- R7: Power down is entered by lowering `cke` with a NOP. It ends with `cke` high when `access_req` is high, `idle_req` drops, or a tick arrives. A tick that ends it produces an auto refresh in the very next cycle.
- R8: `cke` never stays low in power down for more than T_REF cycles. When that limit is reached the sequencer raises `cke` and issues an auto refresh in the next cycle.
- R9: Deep power-down entry drives `cs_n` and `we_n` low, `ras_n` and `cas_n` high, and `cke` low. It sets `data_lost`, which stays set until reset. Ticks during deep power down are discarded. The state ends with `cke` high when `access_req` is high or `deep_req` drops.
- R10: When several requests are present, a pending refresh comes first, then deep power down, then self refresh, then power down. A high `access_req` prevents low-power entry.
- R11: `ready` is high only when the sequencer is idle, no wait is counting and `cke` is high. After an auto refresh with nothing else pending it rises T_RC-1 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_tick | input | 1 | One-cycle pulse requesting one auto refresh |
| sleep_req | input | 1 | Level request for self refresh |
| idle_req | input | 1 | Level request for power down |
| deep_req | input | 1 | Level request for deep power down |
| access_req | input | 1 | Host wants to access; blocks and ends low-power states |
| banks_open | input | 1 | Rows may be open; precharge-all is needed first |
| temp_range | input | 2 | Temperature range for the self-refresh timer setting |
| pasr_sel | input | 3 | Partial-array selection for self refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| addr | output | ADDR_W | Address bus (A10 and the mode-register value) |
| ba | output | 2 | Bank select (mode-register selector) |
| ready | output | 1 | Memory may be accessed |
| data_lost | output | 1 | Array contents lost through deep power down |

## Verification
Some rules hold on every cycle, and the embedded assertions check those. The pins stay silent while a wait is counting and while `cke` is held low. The power-down residency counter stays below T_REF. `ready` is never high with `cke` low, and `data_lost` stays set once it is set. The other behaviours only the bench scenarios can show. These are the exact spacing of queued refreshes, the precharge-to-command and mode-write-to-entry distances, and the encoding of the extended mode value for every temperature and partial-array setting. They also include the discarding of ticks during self refresh and deep power down, the priority order among requests, and the forced refresh that follows a power-down deadline.

// File: rtl/lp_sdram_pwr_seq.sv
`timescale 1ns/1ps
module lp_sdram_pwr_seq #(
  parameter int T_RC   = 7,
  parameter int T_RP   = 3,
  parameter int T_MRD  = 2,
  parameter int T_REF  = 15600,
  parameter int ADDR_W = 12,
  parameter int OWED_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_tick,
  input  logic              sleep_req,
  input  logic              idle_req,
  input  logic              deep_req,
  input  logic              access_req,
  input  logic              banks_open,
  input  logic [1:0]        temp_range,
  input  logic [2:0]        pasr_sel,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              ready,
  output logic              data_lost
);
  localparam int WMAX   = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                        : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int WAIT_W = $clog2(WMAX + 1);
  localparam int PD_W   = $clog2(T_REF + 1);

  typedef enum logic [2:0] {S_IDLE, S_GO, S_SRE, S_SR, S_PD, S_DPD} state_t;
  typedef enum logic [2:0] {G_NONE, G_REF, G_DPD, G_SREF, G_PD} goal_t;

  state_t            state;
  goal_t             goal_q, goal_pick, goal_run;
  logic [WAIT_W-1:0] wait_cnt;
  logic [PD_W-1:0]   pd_cnt;
  logic [OWED_W-1:0] owed;

  always_comb begin
    if (owed != '0)      goal_pick = G_REF;
    else if (access_req) goal_pick = G_NONE;
    else if (deep_req)   goal_pick = G_DPD;
    else if (sleep_req)  goal_pick = G_SREF;
    else if (idle_req)   goal_pick = G_PD;
    else                 goal_pick = G_NONE;
  end

  logic wait_done, idle_fire, start_pre, run_goal, ar_now;
  logic pd_deadline, pd_exit, sr_exit, dpd_exit, owed_clr, owed_inc;

  assign wait_done   = (wait_cnt == '0);
  assign idle_fire   = (state == S_IDLE) && wait_done && (goal_pick != G_NONE);
  assign start_pre   = idle_fire && banks_open;
  assign run_goal    = (idle_fire && !banks_open) || ((state == S_GO) && wait_done);
  assign goal_run    = (state == S_GO) ? goal_q : goal_pick;
  assign ar_now      = run_goal && (goal_run == G_REF);
  assign pd_deadline = (pd_cnt == PD_W'(T_REF - 1));
  assign pd_exit     = access_req || !idle_req || refresh_tick || (owed != '0) || pd_deadline;
  assign sr_exit     = access_req || !sleep_req;
  assign dpd_exit    = access_req || !deep_req;
  assign owed_clr    = (state == S_SR) || (state == S_DPD) || ((state == S_SRE) && wait_done)
                     || (run_goal && (goal_run == G_DPD));
  assign owed_inc    = (refresh_tick || ((state == S_PD) && pd_deadline)) && (owed != '1);
  assign ready       = (state == S_IDLE) && wait_done && cke;

  always_ff @(posedge clk) begin
    if (!rst_n)        owed <= '0;
    else if (owed_clr) owed <= '0;
    else               owed <= owed + OWED_W'(owed_inc) - OWED_W'(ar_now);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      goal_q    <= G_NONE;
      wait_cnt  <= '0;
      pd_cnt    <= '0;
      cs_n      <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      cke       <= 1'b1;
      addr      <= '0;
      ba        <= '0;
      data_lost <= 1'b0;
    end else begin
      cs_n  <= 1'b0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      addr  <= '0;
      ba    <= '0;
      if (!wait_done) wait_cnt <= wait_cnt - 1'b1;
      case (state)
        S_IDLE: if (start_pre) begin
          ras_n    <= 1'b0;
          we_n     <= 1'b0;
          addr     <= ADDR_W'(1) << 10;
          wait_cnt <= WAIT_W'(T_RP - 1);
          goal_q   <= goal_pick;
          state    <= S_GO;
        end
        S_SRE: if (wait_done) begin
          ras_n <= 1'b0;
          cas_n <= 1'b0;
          cke   <= 1'b0;
          state <= S_SR;
        end
        S_SR: if (sr_exit) begin
          cke      <= 1'b1;
          wait_cnt <= WAIT_W'(T_RC - 1);
          state    <= S_IDLE;
        end
        S_PD: begin
          pd_cnt <= pd_cnt + 1'b1;
          if (pd_exit) begin
            cke   <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_DPD: if (dpd_exit) begin
          cke   <= 1'b1;
          state <= S_IDLE;
        end
        default: ;
      endcase
      if (run_goal) begin
        state <= S_IDLE;
        case (goal_run)
          G_REF: begin
            ras_n    <= 1'b0;
            cas_n    <= 1'b0;
            wait_cnt <= WAIT_W'(T_RC - 1);
          end
          G_SREF: begin
            ras_n    <= 1'b0;
            cas_n    <= 1'b0;
            we_n     <= 1'b0;
            ba       <= 2'b10;
            addr     <= ADDR_W'({temp_range, pasr_sel});
            wait_cnt <= WAIT_W'(T_MRD - 1);
            state    <= S_SRE;
          end
          G_PD: begin
            cke    <= 1'b0;
            pd_cnt <= '0;
            state  <= S_PD;
          end
          G_DPD: begin
            we_n      <= 1'b0;
            cke       <= 1'b0;
            data_lost <= 1'b1;
            state     <= S_DPD;
          end
          default: ;
        endcase
      end
    end
  end

  AST_QUIET_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (wait_cnt != '0) |=> ({ras_n, cas_n, we_n} == 3'b111)); // R3
  AST_LOW_CKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!cke && $past(!cke)) |-> ({ras_n, cas_n, we_n} == 3'b111)); // R5
  AST_PD_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (state == S_PD) |-> (pd_cnt < PD_W'(T_REF))); // R8
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) data_lost |=> data_lost); // R9
  AST_READY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n) ready |-> cke); // R11
endmodule

// File: tb/test_lp_sdram_pwr_seq.sv
`timescale 1ns/1ps
module test_lp_sdram_pwr_seq;
  localparam int RC = 7, RP = 3, MRD = 2, REF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh_tick = 0, sleep_req = 0, idle_req = 0, deep_req = 0, access_req = 0, banks_open = 0;
  logic [1:0] temp_range = '0;
  logic [2:0] pasr_sel = '0;
  logic cs_n, ras_n, cas_n, we_n, cke, ready, data_lost;
  logic [11:0] addr;
  logic [1:0] ba;

  always #2.5 clk = ~clk;

  lp_sdram_pwr_seq #(.T_RC(RC), .T_RP(RP), .T_MRD(MRD), .T_REF(REF)) i_lp_sdram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick), .sleep_req(sleep_req),
    .idle_req(idle_req), .deep_req(deep_req), .access_req(access_req), .banks_open(banks_open),
    .temp_range(temp_range), .pasr_sel(pasr_sel), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .addr(addr), .ba(ba), .ready(ready), .data_lost(data_lost));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  int cyc = 0, n_ar = 0, n_pre = 0, n_mrs = 0, n_dpd = 0;
  int t_ar = -1000, t_pre = -1000, t_mrs = -1000, t_sref = -1000, t_dpd = -1000;
  int t_rise = -1000, t_srx = -1000, t_ready_rise = -1000, ar_gap = 0, pd_len = 0, last_pd_len = 0;
  logic [11:0] mrs_addr = '0;
  logic [1:0] mrs_ba = '0;
  bit in_sr = 0, in_pd = 0, in_dpd = 0, prev_cke = 1, prev_ready = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!cs_n && {ras_n, cas_n, we_n} != 3'b111) begin
        chk(cyc - t_ar >= RC, "R3 command too soon after refresh", cyc - t_ar, RC);
        chk(cyc - t_pre >= RP, "R4 command too soon after precharge", cyc - t_pre, RP);
        chk(cyc - t_srx >= RC, "R6 command too soon after self-refresh exit", cyc - t_srx, RC);
        chk(!(in_sr || in_pd || in_dpd), "R5 command while cke held low", 1, 0);
        if ({ras_n, cas_n, we_n} == 3'b001 && cke) begin
          ar_gap = cyc - t_ar; t_ar = cyc; n_ar++;
        end else if ({ras_n, cas_n, we_n} == 3'b001) begin
          t_sref = cyc; in_sr = 1;
        end else if ({ras_n, cas_n, we_n} == 3'b010 && addr[10]) begin
          t_pre = cyc; n_pre++;
        end else if ({ras_n, cas_n, we_n} == 3'b000) begin
          t_mrs = cyc; n_mrs++; mrs_addr = addr; mrs_ba = ba;
        end else if ({ras_n, cas_n, we_n} == 3'b110 && !cke) begin
          t_dpd = cyc; n_dpd++; in_dpd = 1;
        end
      end else if (prev_cke && !cke) begin
        in_pd = 1; pd_len = 0;
      end
      if (in_pd && !cke) begin
        pd_len++;
        if (pd_len > REF) chk(0, "R8 power down too long", pd_len, REF);
      end
      if (!prev_cke && cke) begin
        t_rise = cyc;
        if (in_sr) t_srx = cyc;
        if (in_pd) last_pd_len = pd_len;
        in_sr = 0; in_pd = 0; in_dpd = 0;
      end
      if (!prev_ready && ready) t_ready_rise = cyc;
      prev_cke = cke;
      prev_ready = ready;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a0, p0, m0, d0;
    step(3);
    rst_n = 1;
    step(1);
    chk(!cs_n && ras_n && cas_n && we_n, "R1 NOP after reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(cke && ready, "R1 cke and ready after reset", {cke, ready}, 2'b11);
    chk(!data_lost, "R1 data_lost clear", data_lost, 0);

    for (int nb = 1; nb <= 3; nb++) begin
      a0 = n_ar; p0 = n_pre;
      refresh_tick = 1; step(nb); refresh_tick = 0;
      step(30);
      chk(n_ar == a0 + nb, "R2 one refresh per tick", n_ar - a0, nb);
      chk(n_pre == p0, "R2 no precharge with closed banks", n_pre - p0, 0);
      if (nb > 1) chk(ar_gap == RC, "R3 burst spacing", ar_gap, RC);
      chk(t_ready_rise - t_ar == RC - 1, "R11 ready after refresh", t_ready_rise - t_ar, RC - 1);
    end

    p0 = n_pre; a0 = n_ar;
    banks_open = 1; refresh_tick = 1; step(1); refresh_tick = 0; step(1); banks_open = 0;
    step(20);
    chk(n_pre == p0 + 1 && n_ar == a0 + 1, "R4 precharge before refresh", n_pre - p0, 1);
    chk(t_ar - t_pre == RP, "R4 precharge to refresh distance", t_ar - t_pre, RP);

    for (int tr = 0; tr < 4; tr++) begin
      for (int ps = 0; ps < 8; ps++) begin
        temp_range = 2'(tr); pasr_sel = 3'(ps);
        sleep_req = 1;
        step(MRD + 4);
        chk(mrs_addr == 12'(tr * 8 + ps) && mrs_ba == 2'b10, "R5 mode write value", int'(mrs_addr), tr * 8 + ps);
        chk(t_sref - t_mrs == MRD, "R5 mode write to entry", t_sref - t_mrs, MRD);
        refresh_tick = 1; step(1); refresh_tick = 0;
        step(3);
        chk(!cke, "R5 cke held low in self refresh", cke, 0);
        if (ps % 2 == 1) access_req = 1; else sleep_req = 0;
        step(1);
        access_req = 0; sleep_req = 0;
        chk(cke, "R6 self-refresh exit raises cke", cke, 1);
        a0 = n_ar;
        refresh_tick = 1; step(1); refresh_tick = 0;
        step(RC + 3);
        chk(n_ar == a0 + 1, "R6 stale tick discarded", n_ar - a0, 1);
        chk(t_ar - t_srx == RC, "R6 wait after exit", t_ar - t_srx, RC);
      end
    end

    for (int v = 0; v < 4; v++) begin
      a0 = n_ar;
      idle_req = 1; step(3);
      chk(!cke, "R7 power down entered", cke, 0);
      if (v == 0) begin
        step(5); access_req = 1; step(1); access_req = 0; idle_req = 0;
        chk(cke && n_ar == a0, "R7 exit on access", cke, 1);
      end else if (v == 1) begin
        step(5); idle_req = 0; step(1);
        chk(cke && n_ar == a0, "R7 exit on idle drop", cke, 1);
      end else if (v == 2) begin
        step(5); refresh_tick = 1; step(1); refresh_tick = 0; idle_req = 0;
        chk(cke, "R7 exit on tick", cke, 1);
        step(1);
        chk(n_ar == a0 + 1 && t_ar == t_rise + 1, "R7 refresh right after exit", t_ar - t_rise, 1);
      end else begin
        step(REF + 5);
        chk(last_pd_len == REF, "R8 residency limit", last_pd_len, REF);
        chk(t_ar == t_rise + 1 && n_ar == a0 + 1, "R8 forced refresh", t_ar - t_rise, 1);
        idle_req = 0;
      end
      step(RC + 3);
      chk(cke, "R7 awake after power down", cke, 1);
    end

    a0 = n_ar; d0 = n_dpd; m0 = n_mrs;
    refresh_tick = 1; step(1); refresh_tick = 0;
    deep_req = 1; sleep_req = 1; idle_req = 1;
    step(RC + 4);
    chk(n_dpd == d0 + 1 && n_mrs == m0, "R10 deep wins over sleep and idle", n_dpd - d0, 1);
    chk(t_dpd - t_ar == RC && n_ar == a0 + 1, "R10 refresh first", t_dpd - t_ar, RC);
    chk(data_lost && !cke, "R9 deep power down state", {data_lost, cke}, 2'b10);
    refresh_tick = 1; step(1); refresh_tick = 0; step(2);
    deep_req = 0; sleep_req = 0; idle_req = 0;
    step(1);
    chk(cke, "R9 deep exit raises cke", cke, 1);
    step(RC + 3);
    chk(n_ar == a0 + 1, "R9 ticks discarded in deep power down", n_ar - a0, 1);
    chk(data_lost, "R9 data_lost sticky", data_lost, 1);

    p0 = n_pre; d0 = n_dpd;
    banks_open = 1; deep_req = 1; step(RP + 3);
    chk(n_pre == p0 + 1 && n_dpd == d0 + 1, "R4 precharge before deep entry", n_pre - p0, 1);
    chk(t_dpd - t_pre == RP, "R4 precharge to deep entry", t_dpd - t_pre, RP);
    deep_req = 0; banks_open = 0; step(3);

    m0 = n_mrs;
    sleep_req = 1; idle_req = 1; step(MRD + 3);
    chk(n_mrs == m0 + 1 && !cke, "R10 sleep wins over idle", n_mrs - m0, 1);
    sleep_req = 0; idle_req = 0; step(RC + 2);

    access_req = 1; idle_req = 1; step(10);
    chk(cke && ready, "R10 access blocks entry", {cke, ready}, 2'b11);
    access_req = 0; step(2);
    chk(!cke && !ready, "R11 ready low in power down", {cke, ready}, 2'b00);
    idle_req = 0; step(3);
    chk(cke && ready, "R11 ready after power-down exit", {cke, ready}, 2'b11);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule